// File: doc/BRIEF.md
# Cursor-Based Framebuffer Address Accelerator

This block lets a processor with a narrow address space reach a large pixel memory through a single movable pointer. The processor sees a small slave bus with four strobes. They select the cursor register, a wide-value extension register, a RAM of signed step values, and a pixel access. A pixel access is passed to a memory-side bus master at the address held in the cursor. The processor's write enable, byte selects and write data go with it, and the memory's read data comes back to the processor.

When a pixel access completes, the cursor moves by the step value held in the RAM entry that the slave address picked. A copy loop can then alternate between two entries, one that steps up a line and one that steps down and right, with no explicit pointer writes. Values wider than the data bus move in two parts. The low part travels on the data bus and the high part goes through the extension register.

Top module: `fbca_accel`

## Requirements
- R1: A synchronous active-low reset clears the cursor and the extension register, leaves `m_cyc`/`m_stb` low and keeps `s_ack` low; step RAM contents are not reset.
- R2: A cursor write loads `{extension, s_wdata}` truncated to VW bits. A cursor read returns the low DW cursor bits on `s_rdata` and copies the bits above DW into the extension register.
- R3: An extension write stores the low EXT_W = VW-DW bits of `s_wdata`, and an extension read returns it zero-extended.
- R4: The step RAM has 2**AW entries of VW bits each, addressed by `s_adr`. A write stores `{extension, s_wdata}`. A read returns the low DW bits and copies the upper bits into the extension register.
- R5: A cursor, extension or step RAM access is acknowledged by a one-cycle `s_ack` pulse in the cycle after the strobe is first sampled.
- R6: A pixel access drives `m_adr` with the cursor and forwards `s_we`, `s_sel` and `s_wdata`. Pixel memory read data appears on `s_rdata` while `s_ack` is high. Bit 0 of the byte selects covers data bits 7:0 (little endian).
- R7: `m_cyc`/`m_stb` rise in the cycle after the pixel request is sampled and stay high, with a stable address, until `m_ack`. `s_ack` follows `m_ack` and is never given earlier.
- R8: When a pixel access completes, the cursor becomes the cursor plus the step RAM entry at the slave address sampled at the start. The sum is in two's complement and wraps modulo 2**VW.
- R9: `m_cyc` drops in the cycle after `m_ack`, and only one pixel access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_cyc | input | 1 | Slave bus cycle |
| s_stb_cur | input | 1 | Strobe for the cursor register |
| s_stb_ext | input | 1 | Strobe for the extension register |
| s_stb_mod | input | 1 | Strobe for the step RAM |
| s_stb_pix | input | 1 | Strobe for a pixel access |
| s_we | input | 1 | Slave write enable |
| s_sel | input | DW/8 | Slave byte selects |
| s_adr | input | AW | Step RAM index |
| s_wdata | input | DW | Slave write data |
| s_rdata | output | DW | Slave read data |
| s_ack | output | 1 | Slave acknowledge |
| m_cyc | output | 1 | Master bus cycle |
| m_stb | output | 1 | Master strobe |
| m_we | output | 1 | Master write enable |
| m_adr | output | VW | Master address (cursor) |
| m_sel | output | DW/8 | Master byte selects |
| m_wdata | output | DW | Master write data |
| m_rdata | input | DW | Pixel memory read data |
| m_ack | input | 1 | Pixel memory acknowledge |

## Verification
Pixel writes run through all eight step entries from three starting cursors. The entries hold positive, negative, zero, larger-than-half-range and one-line values, and one start sits just below the top of memory. These runs separate a correct signed, wrapping add from an unsigned or saturating one, and they show whether the right entry was used. Each run uses a different number of memory wait states, which exposes an early or missing acknowledge and an address that moves while the access is pending. Pixel reads of seeded memory words show whether read data is returned. A write with byte select zero shows whether the select is forwarded. A sweep of cursor values across the whole range, read back in two halves, checks that the extension path carries the upper bits.

// File: rtl/fbca_pkg.sv
// Shared definitions for the cursor framebuffer accelerator.
// Assumes the slave issues one strobe at a time.
package fbca_pkg;

    // Register-side target decoded from the slave strobes.
    typedef enum logic [1:0] {
        TGT_CURSOR,
        TGT_EXTEND,
        TGT_MODIFY,
        TGT_NONE
    } reg_tgt_e;

    // Width of the extension register: the cursor bits above the data bus (at least 1).
    function automatic int ext_width(input int vw, input int dw);
        return (vw > dw) ? vw - dw : 1;
    endfunction

endpackage

// File: rtl/fbca_modify_ram.sv
// Step RAM: 2**AW entries of VW-bit signed cursor increments.
// One write port and two asynchronous read ports: one for register reads
// and one that supplies the step for the pending pixel access. No reset.
module fbca_modify_ram #(
    parameter int AW = 3,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [VW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [VW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [VW-1:0] rb_data
);
    localparam int NENT = 1 << AW;

    logic [VW-1:0] mem_q [NENT];

    // Store a step value on a register-side write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/fbca_reg_port.sv
// Register side of the slave bus: decodes the cursor, extension and step RAM
// strobes, acknowledges each access one cycle after it is sampled, and owns the
// extension register that carries the bits above the data bus.
// Assumes only one strobe is high at a time; cursor has priority otherwise.
module fbca_reg_port
    import fbca_pkg::*;
#(
    parameter int DW = 8,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc,
    input  logic          stb_cur,
    input  logic          stb_ext,
    input  logic          stb_mod,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [VW-1:0] cursor,
    input  logic [VW-1:0] ram_rdata,
    output logic          cur_load,
    output logic [VW-1:0] wide_wval,
    output logic          ram_we,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    localparam int EXT_W = ext_width(VW, DW);
    localparam int CAT_W = EXT_W + DW;

    reg_tgt_e          tgt;
    logic              fire;
    logic              ack_q;
    logic [EXT_W-1:0]  ext_q;
    logic [DW-1:0]     rdata_q;
    logic [CAT_W-1:0]  wr_cat;
    logic [CAT_W-1:0]  cur_cat;
    logic [CAT_W-1:0]  ram_cat;

    // Decode which register-side target the current strobe addresses.
    always_comb begin
        if (!cyc)         tgt = TGT_NONE;
        else if (stb_cur) tgt = TGT_CURSOR;
        else if (stb_ext) tgt = TGT_EXTEND;
        else if (stb_mod) tgt = TGT_MODIFY;
        else              tgt = TGT_NONE;
    end

    assign fire    = (tgt != TGT_NONE) && !ack_q;
    assign wr_cat  = {ext_q, wdata};
    assign cur_cat = CAT_W'(cursor);
    assign ram_cat = CAT_W'(ram_rdata);

    assign wide_wval = wr_cat[VW-1:0];
    assign cur_load  = fire && we && (tgt == TGT_CURSOR);
    assign ram_we    = fire && we && (tgt == TGT_MODIFY);

    // Acknowledge, read data capture and extension register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            ext_q   <= '0;
            rdata_q <= '0;
        end else begin
            ack_q <= fire;
            if (fire) begin
                unique case (tgt)
                    TGT_CURSOR: begin
                        if (!we) begin
                            rdata_q <= cur_cat[DW-1:0];
                            ext_q   <= cur_cat[CAT_W-1:DW];
                        end
                    end
                    TGT_EXTEND: begin
                        if (we) ext_q   <= EXT_W'(wdata);
                        else    rdata_q <= DW'(ext_q);
                    end
                    TGT_MODIFY: begin
                        if (!we) begin
                            rdata_q <= ram_cat[DW-1:0];
                            ext_q   <= ram_cat[CAT_W-1:DW];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ack   = ack_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/fbca_pixel_port.sv
// Pixel side: turns a slave pixel request into one master bus access at the
// cursor address, holds it until the memory acknowledges, and remembers which
// step RAM entry the access selected. Assumes the slave holds its strobe
// until acknowledged (classic single-access handshake).
module fbca_pixel_port #(
    parameter int AW = 3,
    parameter int VW = 10,
    parameter int DW = 8,
    parameter int SW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] adr,
    input  logic [VW-1:0] cursor,
    input  logic          m_ack,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] step_idx,
    output logic          m_we,
    output logic [VW-1:0] m_adr,
    output logic [SW-1:0] m_sel,
    output logic [DW-1:0] m_wdata
);
    logic          busy_q;
    logic          we_q;
    logic [VW-1:0] adr_q;
    logic [SW-1:0] sel_q;
    logic [DW-1:0] wdata_q;
    logic [AW-1:0] idx_q;

    // Start an access when idle, finish it on the memory acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            adr_q   <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q  <= 1'b1;
                we_q    <= we;
                adr_q   <= cursor;
                sel_q   <= sel;
                wdata_q <= wdata;
                idx_q   <= adr;
            end
        end else if (m_ack) begin
            busy_q <= 1'b0;
        end
    end

    assign busy     = busy_q;
    assign done     = busy_q && m_ack;
    assign step_idx = idx_q;
    assign m_we     = we_q;
    assign m_adr    = adr_q;
    assign m_sel    = sel_q;
    assign m_wdata  = wdata_q;

endmodule

// File: rtl/fbca_cursor.sv
// Cursor register: loaded from the slave or advanced by a signed step when a
// pixel access completes. Arithmetic wraps modulo 2**VW.
module fbca_cursor #(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    input  logic          step_en,
    input  logic [VW-1:0] step,
    output logic [VW-1:0] cursor
);
    logic [VW-1:0] cur_q;

    // Hold, load or advance the pixel pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (load)    cur_q <= load_val;
        else if (step_en) cur_q <= cur_q + step;
    end

    assign cursor = cur_q;

endmodule

// File: rtl/fbca_accel.sv
// Top of the cursor framebuffer accelerator. A slave bus with four strobes
// reaches the cursor, extension register, step RAM, or pixel memory; a master
// bus performs pixel accesses at the cursor, after which the cursor advances by
// the selected step. Assumes one slave strobe at a time and DW a multiple of 8.
module fbca_accel #(
    parameter int AW = 3,
    parameter int VW = 10,
    parameter int DW = 8,
    parameter int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_cyc,
    input  logic          s_stb_cur,
    input  logic          s_stb_ext,
    input  logic          s_stb_mod,
    input  logic          s_stb_pix,
    input  logic          s_we,
    input  logic [SW-1:0] s_sel,
    input  logic [AW-1:0] s_adr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          s_ack,
    output logic          m_cyc,
    output logic          m_stb,
    output logic          m_we,
    output logic [VW-1:0] m_adr,
    output logic [SW-1:0] m_sel,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ack
);
    logic [VW-1:0] cursor_q;
    logic [VW-1:0] ram_ra_data;
    logic [VW-1:0] step_val;
    logic [VW-1:0] wide_wval;
    logic          cur_load;
    logic          ram_we;
    logic          reg_ack;
    logic [DW-1:0] reg_rdata;
    logic          pix_busy;
    logic          pix_done;
    logic [AW-1:0] step_idx;

    fbca_reg_port #(.DW(DW), .VW(VW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (s_cyc),
        .stb_cur   (s_stb_cur),
        .stb_ext   (s_stb_ext),
        .stb_mod   (s_stb_mod),
        .we        (s_we),
        .wdata     (s_wdata),
        .cursor    (cursor_q),
        .ram_rdata (ram_ra_data),
        .cur_load  (cur_load),
        .wide_wval (wide_wval),
        .ram_we    (ram_we),
        .ack       (reg_ack),
        .rdata     (reg_rdata)
    );

    fbca_modify_ram #(.AW(AW), .VW(VW)) u_steps (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (s_adr),
        .wdata   (wide_wval),
        .ra_addr (s_adr),
        .ra_data (ram_ra_data),
        .rb_addr (step_idx),
        .rb_data (step_val)
    );

    fbca_pixel_port #(.AW(AW), .VW(VW), .DW(DW), .SW(SW)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (s_cyc && s_stb_pix),
        .we       (s_we),
        .sel      (s_sel),
        .wdata    (s_wdata),
        .adr      (s_adr),
        .cursor   (cursor_q),
        .m_ack    (m_ack),
        .busy     (pix_busy),
        .done     (pix_done),
        .step_idx (step_idx),
        .m_we     (m_we),
        .m_adr    (m_adr),
        .m_sel    (m_sel),
        .m_wdata  (m_wdata)
    );

    fbca_cursor #(.VW(VW)) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cur_load),
        .load_val (wide_wval),
        .step_en  (pix_done),
        .step     (step_val),
        .cursor   (cursor_q)
    );

    assign m_cyc   = pix_busy;
    assign m_stb   = pix_busy;
    assign s_ack   = reg_ack || pix_done;
    assign s_rdata = pix_done ? m_rdata : reg_rdata;

endmodule

// File: rtl/fbca_checker.sv
// Protocol checks for fbca_accel, attached by bind. Observes the master bus,
// the slave acknowledge and the cursor register.
module fbca_checker #(
    parameter int VW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_cyc,
    input logic          m_stb,
    input logic          m_we,
    input logic          m_ack,
    input logic [VW-1:0] m_adr,
    input logic          s_ack,
    input logic [VW-1:0] cursor
);
    logic rst_seen_q = 1'b0;

    // Track whether reset was applied at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            // R1: after a reset edge the master is idle and no ack is given
            a_r1_idle_after_reset: assert (!m_cyc && !m_stb && !s_ack);
        end
    end

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && !m_ack) |=> (m_cyc && m_stb && $stable(m_adr) && $stable(m_we)));

    a_r7_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && !m_ack) |-> !s_ack);

    a_r9_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && m_ack) |=> !m_cyc);

    a_r6_addr_is_cursor: assert property (@(posedge clk) disable iff (!rst_n)
        m_cyc |-> (m_adr == cursor));

    a_r5_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ack && !m_cyc) |=> !s_ack);

endmodule

bind fbca_accel fbca_checker #(.VW(VW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .m_cyc  (m_cyc),
    .m_stb  (m_stb),
    .m_we   (m_we),
    .m_ack  (m_ack),
    .m_adr  (m_adr),
    .s_ack  (s_ack),
    .cursor (cursor_q)
);

// File: tb/sim_fbca_accel.sv
module sim_fbca_accel;
    localparam int AW    = 3;
    localparam int VW    = 10;
    localparam int DW    = 8;
    localparam int SW    = DW / 8;
    localparam int NMOD  = 1 << AW;
    localparam int DEPTH = 1 << VW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_cyc = 1'b0, s_stb_cur = 1'b0, s_stb_ext = 1'b0;
    logic          s_stb_mod = 1'b0, s_stb_pix = 1'b0, s_we = 1'b0;
    logic [SW-1:0] s_sel = '0;
    logic [AW-1:0] s_adr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic [DW-1:0] s_rdata;
    logic          s_ack;
    logic          m_cyc, m_stb, m_we;
    logic [VW-1:0] m_adr;
    logic [SW-1:0] m_sel;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_rdata = '0;
    logic          m_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int wait_n = 0;
    int wcnt   = 0;
    int last_adr = -1, last_we = -1, last_sel = -1;
    int exp_cur = 0;
    int modv [NMOD];
    logic [DW-1:0] mem [DEPTH];
    logic          poke = 1'b0;
    logic [VW-1:0] poke_a = '0;
    logic [DW-1:0] poke_d = '0;

    always #5 clk = ~clk;

    fbca_accel #(.AW(AW), .VW(VW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .s_cyc(s_cyc), .s_stb_cur(s_stb_cur),
        .s_stb_ext(s_stb_ext), .s_stb_mod(s_stb_mod), .s_stb_pix(s_stb_pix),
        .s_we(s_we), .s_sel(s_sel), .s_adr(s_adr), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .s_ack(s_ack), .m_cyc(m_cyc), .m_stb(m_stb),
        .m_we(m_we), .m_adr(m_adr), .m_sel(m_sel), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack)
    );

    // Pixel memory model with wait_n wait states.
    always @(posedge clk) begin
        if (poke) mem[poke_a] <= poke_d;
        if (m_cyc && m_stb && !m_ack) begin
            if (wcnt == wait_n) begin
                m_ack <= 1'b1;
                wcnt  <= 0;
                m_rdata <= mem[m_adr];
                if (m_we && m_sel[0]) mem[m_adr] <= m_wdata;
                last_adr <= int'(m_adr);
                last_we  <= int'(m_we);
                last_sel <= int'(m_sel);
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            m_ack <= 1'b0;
            wcnt  <= 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // tgt: 0 cursor, 1 extension, 2 step RAM, 3 pixel
    task automatic xfer(input int tgt, input bit we, input int a, input int d,
                        input int sel, output int q, output int lat);
        @(negedge clk);
        s_cyc = 1'b1; s_we = we; s_adr = AW'(a); s_wdata = DW'(d); s_sel = SW'(sel);
        s_stb_cur = (tgt == 0); s_stb_ext = (tgt == 1);
        s_stb_mod = (tgt == 2); s_stb_pix = (tgt == 3);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!s_ack && lat < 50);
        q = int'(s_rdata);
        s_cyc = 1'b0; s_stb_cur = 1'b0; s_stb_ext = 1'b0;
        s_stb_mod = 1'b0; s_stb_pix = 1'b0; s_we = 1'b0;
        if (tgt < 3) chk("R5", "register ack latency", lat, 1);
        @(negedge clk);
        chk("R5", "ack released", int'(s_ack), 0);
        if (tgt == 3) chk("R9", "master released", int'(m_cyc), 0);
    endtask

    task automatic rd_cursor(output int v);
        int lo, hi, lat;
        xfer(0, 1'b0, 0, 0, 1, lo, lat);
        xfer(1, 1'b0, 0, 0, 1, hi, lat);
        v = (hi << DW) | lo;
    endtask

    task automatic set_cursor(input int v);
        int q, lat;
        xfer(1, 1'b1, 0, (v & (DEPTH - 1)) >> DW, 1, q, lat);
        xfer(0, 1'b1, 0, v & 255, 1, q, lat);
    endtask

    task automatic set_mod(input int i, input int v);
        int q, lat;
        xfer(1, 1'b1, 0, (v & (DEPTH - 1)) >> DW, 1, q, lat);
        xfer(2, 1'b1, i, v & 255, 1, q, lat);
    endtask

    task automatic pixel(input bit we, input int i, input int d, input int sel, output int q);
        int lat, cur;
        xfer(3, we, i, d, sel, q, lat);
        chk("R7", "pixel ack latency", lat, 2 + wait_n);
        chk("R6", "master address", last_adr, exp_cur);
        chk("R6", "master we", last_we, int'(we));
        chk("R6", "master sel", last_sel, sel);
        if (we && sel != 0) chk("R6", "written pixel", int'(mem[exp_cur]), d & 255);
        exp_cur = (((exp_cur + modv[i]) % DEPTH) + DEPTH) % DEPTH;
        rd_cursor(cur);
        chk("R8", "cursor after step", cur, exp_cur);
    endtask

    initial begin
        int q, lat, v;
        modv = '{1, -1, 32, -32, 0, 513, -1000, 7};
        repeat (3) @(negedge clk);
        chk("R1", "m_cyc in reset", int'(m_cyc), 0);
        chk("R1", "s_ack in reset", int'(s_ack), 0);
        rst_n = 1'b1;
        xfer(0, 1'b0, 0, 0, 1, q, lat);
        chk("R1", "cursor low after reset", q, 0);
        xfer(1, 1'b0, 0, 0, 1, q, lat);
        chk("R1", "extension after reset", q, 0);

        // R3: extension register sweep
        for (int e = 0; e < 8; e++) begin
            xfer(1, 1'b1, 0, e * 65, 1, q, lat);
            xfer(1, 1'b0, 0, 0, 1, q, lat);
            chk("R3", "extension readback", q, (e * 65) & ((1 << (VW - DW)) - 1));
        end

        // R2: cursor sweep across the range, read back in two halves
        for (int c = 0; c < DEPTH; c += 93) begin
            set_cursor(c);
            xfer(1, 1'b1, 0, 0, 1, q, lat);
            rd_cursor(v);
            chk("R2", "cursor readback", v, c);
        end

        // R4: step RAM contents
        for (int i = 0; i < NMOD; i++) set_mod(i, modv[i]);
        for (int i = 0; i < NMOD; i++) begin
            int lo, hi;
            xfer(1, 1'b1, 0, 0, 1, q, lat);
            xfer(2, 1'b0, i, 0, 1, lo, lat);
            xfer(1, 1'b0, 0, 0, 1, hi, lat);
            chk("R4", "step entry readback", (hi << DW) | lo, modv[i] & (DEPTH - 1));
        end

        // R6 R7 R8: pixel writes through every entry with varying wait states
        for (int w = 0; w < 3; w++) begin
            int starts [3] = '{100, 1020, 5};
            wait_n = w;
            exp_cur = starts[w];
            set_cursor(exp_cur);
            for (int i = 0; i < NMOD; i++) pixel(1'b1, i, w * 37 + i * 11 + 1, 1, q);
        end

        // R6: pixel reads of seeded memory
        wait_n = 1;
        for (int i = 0; i < NMOD; i++) begin
            int seed;
            seed = (exp_cur * 7 + 3) & 255;
            @(negedge clk);
            poke = 1'b1; poke_a = VW'(exp_cur); poke_d = DW'(seed);
            @(negedge clk);
            poke = 1'b0;
            pixel(1'b0, i, 0, 1, q);
            chk("R6", "pixel read data", q, seed);
        end

        // R6: byte select zero leaves memory unchanged, cursor still steps (R8)
        begin
            int keep;
            keep = exp_cur;
            @(negedge clk);
            poke = 1'b1; poke_a = VW'(keep); poke_d = 8'hA5;
            @(negedge clk);
            poke = 1'b0;
            pixel(1'b1, 2, 8'h5A, 0, q);
            chk("R6", "deselected byte kept", int'(mem[keep]), 8'hA5);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule